// File: doc/BRIEF.md
# Rotating Four-Shape Waveform Sequencer

This block feeds one 8-bit DAC channel with a stream of unsigned samples. A sample-tick strobe sets the sample rate. Each accepted tick produces one sample and moves the phase on by one step. A period is 2^PHASE_BITS ticks long, and every shape uses that same period. Only the sine shape needs stored values. It uses a quarter-wave table that the block computes itself at elaboration. The other three shapes are computed from the phase.

A period counter decides when to change shape. Once a shape has played `PERIODS_PER_SHAPE` complete periods, the block moves to the next shape. The order is sine, square, sawtooth, triangle, and then back to sine. With the default 256-tick period and a 10.24 kHz tick, one period lasts 25 ms and one shape lasts 25 s. An enable input pauses the block. While enable is low, ticks have no effect.

Top module: `wave_sequencer`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it is released, `sample_o` is 0x00, `sample_valid_o` is 0, `shape_o` is 0 (sine) and `shape_change_o` is 0. The phase and the period count are cleared.
- R2: Each cycle in which `tick` and `en` are both high causes `sample_valid_o` to be high for exactly one cycle on the following cycle. `sample_o` then holds the sample for the shape and phase in force at that tick. The phase then advances by one, modulo N = 2^PHASE_BITS.
- R3: A tick while `en` is low produces no valid pulse. It also leaves the phase, the period count and the shape unchanged, so the next enabled tick continues from the same point.
- R4: Square (code 1): the sample is 0xFF when phase < N/2 and 0x00 otherwise.
- R5: Sawtooth (code 2): the sample is floor(phase*255/(N-1)), so it runs from 0x00 to 0xFF.
- R6: Triangle (code 3): let t = phase for phase <= N/2, and t = N-phase otherwise. The sample is floor(t*255/(N/2)). The 0xFF peak occurs once per period.
- R7: Sine (code 0): let H = N/2 and m = phase mod H. Let a = floor(2032*m*(H-m) / (5*H*H - 4*m*(H-m))). The sample is 0x80+a when phase < H and 0x80-a otherwise, so phase 0 gives 0x80.
- R8: The shape code changes only when a period ends. This happens on the tick where the phase wraps and the period count reaches `PERIODS_PER_SHAPE`. The code then advances 0→1→2→3→0. `shape_o` shows the shape that the next sample will use.
- R9: `shape_change_o` is high for one cycle, in the same cycle as the valid pulse of the last sample of the old shape. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes the sequencer |
| tick | input | 1 | Sample-rate strobe |
| sample_o | output | 8 | Unsigned sample code |
| sample_valid_o | output | 1 | One-cycle pulse per produced sample |
| shape_o | output | 2 | Shape code for the next sample |
| shape_change_o | output | 1 | One-cycle pulse when the shape advances |

## Verification
The bench builds the block with PHASE_BITS = 4 (a 16-tick period) and three periods per shape. At these values a full rotation takes 192 enabled ticks. The bench can therefore run every shape transition and the wrap back to sine more than once. The small period also puts each shape's boundary samples close together: the square edge, the single triangle peak, the sawtooth top and the sine quarter points. Enable-low gaps, idle ticks and a reset in the middle of a shape exercise the freeze and restart behaviour.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
    localparam int SAMPLE_W = 8;

    typedef enum logic [1:0] {
        SHP_SINE   = 2'd0,
        SHP_SQUARE = 2'd1,
        SHP_SAW    = 2'd2,
        SHP_TRI    = 2'd3
    } shape_e;

    function automatic shape_e next_shape(input shape_e s);
        return shape_e'(s + 2'd1);
    endfunction
endpackage

// File: rtl/wseq_sine_quarter.sv
module wseq_sine_quarter #(
    parameter int PHASE_BITS = 8
) (
    input  logic [PHASE_BITS-2:0] idx_i,
    output logic [6:0]            amp_o
);
    localparam int HALF = 1 << (PHASE_BITS - 1);
    localparam int QTR  = 1 << (PHASE_BITS - 2);

    function automatic longint amp_of(input longint k);
        longint prod;
        prod = k * (HALF - k);
        return (2032 * prod) / (5 * HALF * HALF - 4 * prod);
    endfunction

    logic [6:0] tab [QTR+1];

    for (genvar k = 0; k <= QTR; k++) begin : g_tab
        assign tab[k] = 7'(amp_of(k));
    end

    always_comb begin
        amp_o = 7'd0;
        if (int'(idx_i) <= QTR) amp_o = tab[idx_i];
    end
endmodule

// File: rtl/wseq_timebase.sv
module wseq_timebase
    import wseq_pkg::*;
#(
    parameter int PHASE_BITS        = 8,
    parameter int PERIODS_PER_SHAPE = 1000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_i,
    output logic [PHASE_BITS-1:0] phase_o,
    output shape_e                shape_o,
    output logic                  change_o
);
    localparam int PER_W = $clog2(PERIODS_PER_SHAPE);
    localparam logic [PHASE_BITS-1:0] PH_LAST  = '1;
    localparam logic [PER_W-1:0]      PER_LAST = PER_W'(PERIODS_PER_SHAPE - 1);

    typedef struct packed {
        logic [PHASE_BITS-1:0] phase;
        logic [PER_W-1:0]      period;
        shape_e                shape;
        logic                  change;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.change = 1'b0;
        if (step_i) begin
            if (st_q.phase == PH_LAST) begin
                st_d.phase = '0;
                if (st_q.period == PER_LAST) begin
                    st_d.period = '0;
                    st_d.shape  = next_shape(st_q.shape);
                    st_d.change = 1'b1;
                end else begin
                    st_d.period = st_q.period + 1'b1;
                end
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: '0, period: '0, shape: SHP_SINE, change: 1'b0};
        else     st_q <= st_d;
    end

    assign phase_o  = st_q.phase;
    assign shape_o  = st_q.shape;
    assign change_o = st_q.change;

    a_r3_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> ($stable(st_q.phase) && $stable(st_q.period) && $stable(st_q.shape)));
    a_r8_shape_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (st_q.shape != $past(st_q.shape)) |-> (st_q.shape == next_shape($past(st_q.shape))));
    a_r8_shape_only_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (st_q.shape != $past(st_q.shape)) |-> (st_q.phase == '0 && st_q.period == '0));
    a_r2_phase_advances: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (st_q.phase == $past(st_q.phase) + 1'b1));
endmodule

// File: rtl/wseq_shaper.sv
module wseq_shaper
    import wseq_pkg::*;
#(
    parameter int PHASE_BITS = 8
) (
    input  logic [PHASE_BITS-1:0] phase_i,
    input  shape_e                shape_i,
    output logic [SAMPLE_W-1:0]   sample_o
);
    localparam int N    = 1 << PHASE_BITS;
    localparam int QTR  = 1 << (PHASE_BITS - 2);
    localparam int PW_W = PHASE_BITS + SAMPLE_W;

    logic                  upper;
    logic [PHASE_BITS-2:0] m, sine_idx;
    logic [PHASE_BITS-1:0] mirror, tri_t;
    logic [6:0]            amp;
    logic [PW_W-1:0]       saw_prod, tri_prod;
    logic [SAMPLE_W-1:0]   sine_v, square_v, saw_v, tri_v;

    assign upper  = phase_i[PHASE_BITS-1];
    assign m      = phase_i[PHASE_BITS-2:0];
    assign mirror = (PHASE_BITS'(1) << (PHASE_BITS - 1)) - {1'b0, m};

    always_comb begin
        if (int'(m) <= QTR) sine_idx = m;
        else                sine_idx = mirror[PHASE_BITS-2:0];
    end

    wseq_sine_quarter #(.PHASE_BITS(PHASE_BITS)) u_rom (
        .idx_i (sine_idx),
        .amp_o (amp)
    );

    assign sine_v   = upper ? (8'h80 - {1'b0, amp}) : (8'h80 + {1'b0, amp});
    assign square_v = upper ? 8'h00 : 8'hFF;

    assign saw_prod = PW_W'(phase_i) * PW_W'(255);
    assign saw_v    = SAMPLE_W'(saw_prod / PW_W'(N - 1));

    assign tri_t    = upper ? (~phase_i + 1'b1) : phase_i;
    assign tri_prod = PW_W'(tri_t) * PW_W'(255);
    assign tri_v    = SAMPLE_W'(tri_prod >> (PHASE_BITS - 1));

    always_comb begin
        unique case (shape_i)
            SHP_SINE:   sample_o = sine_v;
            SHP_SQUARE: sample_o = square_v;
            SHP_SAW:    sample_o = saw_v;
            default:    sample_o = tri_v;
        endcase
    end
endmodule

// File: rtl/wave_sequencer.sv
module wave_sequencer
    import wseq_pkg::*;
#(
    parameter int PHASE_BITS        = 8,
    parameter int PERIODS_PER_SHAPE = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    output logic [7:0] sample_o,
    output logic       sample_valid_o,
    output logic [1:0] shape_o,
    output logic       shape_change_o
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        logic                valid;
    } out_state_t;

    out_state_t            out_d, out_q;
    logic                  step;
    logic [PHASE_BITS-1:0] phase;
    shape_e                shape;
    logic                  change;
    logic [SAMPLE_W-1:0]   shaped;

    assign step = tick && en;

    wseq_timebase #(
        .PHASE_BITS        (PHASE_BITS),
        .PERIODS_PER_SHAPE (PERIODS_PER_SHAPE)
    ) u_time (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .phase_o  (phase),
        .shape_o  (shape),
        .change_o (change)
    );

    wseq_shaper #(.PHASE_BITS(PHASE_BITS)) u_shape (
        .phase_i  (phase),
        .shape_i  (shape),
        .sample_o (shaped)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = step;
        if (step) out_d.sample = shaped;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign sample_o       = out_q.sample;
    assign sample_valid_o = out_q.valid;
    assign shape_o        = shape;
    assign shape_change_o = change;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sample_valid_o && !shape_change_o && shape_o == 2'd0));
    a_r2_valid_after_step: assert property (@(posedge clk) disable iff (rst)
        step |=> sample_valid_o);
    a_r3_no_valid_when_idle: assert property (@(posedge clk) disable iff (rst)
        !step |=> !sample_valid_o);
    a_r9_change_with_valid: assert property (@(posedge clk) disable iff (rst)
        shape_change_o |-> sample_valid_o);
    a_r9_change_single: assert property (@(posedge clk) disable iff (rst)
        shape_change_o |=> !shape_change_o);
endmodule

// File: tb/sim_wave_sequencer.sv
module sim_wave_sequencer;
    localparam int PB  = 4;
    localparam int PER = 3;
    localparam int N   = 1 << PB;
    localparam int H   = N / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] sample;
    logic       valid;
    logic [1:0] shape;
    logic       chg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] smp;
        logic [1:0] played;
        logic [1:0] after;
        bit         chg;
    } exp_t;
    exp_t q[$];

    int m_phase, m_period, m_shape;

    always #10 clk = ~clk;

    wave_sequencer #(.PHASE_BITS(PB), .PERIODS_PER_SHAPE(PER)) u0 (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .tick           (tick),
        .sample_o       (sample),
        .sample_valid_o (valid),
        .shape_o        (shape),
        .shape_change_o (chg)
    );

    function automatic int model_sample(int shp, int p);
        int mm, a, t;
        case (shp)
            0: begin
                mm = p % H;
                a = (2032 * mm * (H - mm)) / (5 * H * H - 4 * mm * (H - mm));
                return (p < H) ? 128 + a : 128 - a;
            end
            1: return (p < H) ? 255 : 0;
            2: return (p * 255) / (N - 1);
            default: begin
                t = (p <= H) ? p : N - p;
                return (t * 255) / H;
            end
        endcase
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic drive(bit t, bit e);
        exp_t it;
        @(negedge clk);
        tick = t;
        en   = e;
        if (t && e) begin
            it.smp    = 8'(model_sample(m_shape, m_phase));
            it.played = 2'(m_shape);
            it.chg    = 0;
            if (m_phase == N - 1) begin
                m_phase = 0;
                if (m_period == PER - 1) begin
                    m_period = 0;
                    m_shape  = (m_shape + 1) % 4;
                    it.chg   = 1;
                end else m_period++;
            end else m_phase++;
            it.after = 2'(m_shape);
            q.push_back(it);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; tick = 0; en = 0;
        repeat (2) @(negedge clk);
        m_phase = 0; m_period = 0; m_shape = 0;
        check("R1 valid in reset", int'(valid), 0);
        check("R1 shape in reset", int'(shape), 0);
        rst = 0;
        @(posedge clk); #2;
        check("R1 sample after reset", int'(sample), 0);
        check("R1 valid after reset", int'(valid), 0);
        check("R1 shape after reset", int'(shape), 0);
        check("R1 change after reset", int'(chg), 0);
    endtask

    // monitor: pops one expected item per valid pulse
    initial begin
        exp_t it;
        forever begin
            @(posedge clk); #2;
            if (!rst) begin
                if (valid) begin
                    if (q.size() == 0) begin
                        check("R3 unexpected valid", 1, 0);
                    end else begin
                        it = q.pop_front();
                        case (it.played)
                            2'd0: check("R7 sine sample", int'(sample), int'(it.smp));
                            2'd1: check("R4 square sample", int'(sample), int'(it.smp));
                            2'd2: check("R5 sawtooth sample", int'(sample), int'(it.smp));
                            default: check("R6 triangle sample", int'(sample), int'(it.smp));
                        endcase
                        check("R8 shape code", int'(shape), int'(it.after));
                        check("R9 change pulse", int'(chg), int'(it.chg));
                    end
                end else begin
                    check("R9 change without sample", int'(chg), 0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: continuous ticks over a full rotation and wrap back to sine
        for (int i = 0; i < 4 * PER * N + N; i++) drive(1, 1);
        // R3: disabled ticks interleaved with enabled ones and idle gaps
        for (int i = 0; i < 2 * PER * N; i++) begin
            drive(1, (i % 3) != 1);
            if (i % 5 == 0) drive(0, 1);
        end
        repeat (3) drive(1, 0);
        drive(0, 0);
        drive(0, 0);
        check("R2 all samples delivered", q.size(), 0);
        // reset in the middle of a shape restarts at sine, phase zero
        for (int i = 0; i < 37; i++) drive(1, 1);
        drive(0, 0);
        drive(0, 0);
        do_reset();
        for (int i = 0; i < 4 * PER * N + 5; i++) drive(1, 1);
        drive(0, 0);
        drive(0, 0);
        drive(0, 0);
        check("R2 all samples delivered at end", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule